// File: doc/BRIEF.md
# Flash status auto-polling engine

This block lets a flash controller wait for a serial memory to reach a given state without software in the loop. On a start pulse it samples its configuration and then asks a bus phase sequencer, over and over, to run a status read. Each request stands for one single-lane instruction byte, no address phase, no dummy cycles, and a single-lane data phase of a chosen number of status bytes. Every returned byte is ANDed with a mask and compared with a match value. A poll matches only when every byte in it compares equal.

Between two polls the engine waits a programmable gap, given in serial clock periods and scaled by a fixed ratio of system clocks to serial clocks. With automatic stop enabled the first matching poll ends the loop. Independently, a timeout counted in system clock cycles from the start aborts the loop. Typical uses are waiting for the write-in-progress bit to clear (mask on that bit, match zero) and waiting for the write-enable latch to set (mask and match both equal to that bit). A long timeout is loaded for sector or bulk erase and a short one for everything else.

Top module: `flash_poll_engine`

## Requirements
- R1: After reset, cmd_req_o, done_o, matched_o and timeout_o are 0 and status_o is 8'h00.
- R2: A poll request holds cmd_req_o high until the cycle in which cmd_ack_i is sampled high. While requesting, cmd_opcode_o carries the STATUS_OP parameter (default 8'h05) and cmd_len_o carries the status byte count, with a count of 0 treated as 1.
- R3: A status byte b passes when (b & mask) == match. A poll matches only if all of its bytes pass.
- R4: With automatic stop set, a matching poll ends the loop. done_o pulses in the cycle after the final byte is accepted, with matched_o=1 and timeout_o=0, and no further request follows.
- R5: After a poll that does not end the loop, cmd_req_o stays low for exactly max(interval_i*CLK_DIV, 1) cycles counted from the cycle after the final byte, and then rises.
- R6: With automatic stop clear, polling continues past matching polls until the timeout. At that point matched_o holds the result of the last completed poll and timeout_o=1.
- R7: With timeout_i = T >= 1, a loop that does not stop on a match raises done_o and timeout_o in the (T+1)-th cycle after the start cycle, and cmd_req_o falls at the same time.
- R8: With timeout_i = 0 the loop never times out.
- R9: A matching final byte in the very cycle the timeout expires counts as a match (matched_o=1, timeout_o=0).
- R10: done_o is high for one cycle only. A start pulse while the loop is busy is ignored, including the configuration presented with it.
- R11: status_o holds the most recently accepted status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse; samples the configuration |
| mask_i | input | 8 | Bit mask applied to each status byte |
| match_i | input | 8 | Value the masked byte must equal |
| interval_i | input | IVL_W | Gap between polls, in serial clock periods |
| len_i | input | LEN_W | Status bytes per poll (0 means 1) |
| auto_stop_i | input | 1 | End the loop on the first matching poll |
| timeout_i | input | TMO_W | Timeout in system cycles (0 disables) |
| cmd_req_o | output | 1 | Request to the phase sequencer for one status read |
| cmd_ack_i | input | 1 | Sequencer accepts the request |
| cmd_opcode_o | output | 8 | Instruction byte of the status read |
| cmd_len_o | output | LEN_W | Number of status bytes requested |
| rx_valid_i | input | 1 | A status byte is present on rx_byte_i |
| rx_byte_i | input | 8 | Returned status byte |
| done_o | output | 1 | One-cycle pulse at loop end |
| matched_o | output | 1 | Result of the last completed poll |
| timeout_o | output | 1 | Loop ended by timeout |
| status_o | output | 8 | Last accepted status byte |

## Verification
Some properties are checked on every cycle: done lasting one cycle, the request staying up until accepted and never appearing while idle, a stopping match or an expired timeout producing the right done flags one cycle later, and a non-stopping poll never ending the loop. Timeout combined with a match never occurs under automatic stop. The exact gap length, the timeout arrival cycle, the full 256-value sweep of the mask comparison, multi-byte AND matching, and the ignored second start depend on cycle counting against stimulus. Only the bench's scenarios show those.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_RECV,
    ST_GAP
  } poll_state_e;

  // masked compare of one status byte
  function automatic logic byte_ok(input logic [7:0] b, input logic [7:0] m,
                                   input logic [7:0] v);
    return (b & m) == v;
  endfunction

  // inter-poll gap in system cycles
  function automatic int unsigned gap_len(input int unsigned ival,
                                          input int unsigned div);
    return ival * div;
  endfunction

  // byte count with zero promoted to one
  function automatic int unsigned eff_len(input int unsigned n);
    return (n == 0) ? 1 : n;
  endfunction

endpackage

// File: rtl/fpe_compare.sv
module fpe_compare
  import flash_poll_pkg::*;
#(
  parameter int LEN_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             rx_fire_i,
  input  logic [7:0]       rx_byte_i,
  input  logic [7:0]       mask_i,
  input  logic [7:0]       match_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             poll_end_o,
  output logic             poll_ok_o
);
  logic [LEN_W-1:0] cnt_q;
  logic             acc_q;
  logic             this_ok;

  assign this_ok    = byte_ok(rx_byte_i, mask_i, match_i);
  assign poll_end_o = rx_fire_i && (cnt_q == LEN_W'(len_i - 1'b1));
  assign poll_ok_o  = acc_q && this_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      acc_q <= 1'b1;
    end else if (clear_i) begin
      cnt_q <= '0;
      acc_q <= 1'b1;
    end else if (rx_fire_i) begin
      cnt_q <= cnt_q + 1'b1;
      acc_q <= acc_q && this_ok;
    end
  end
endmodule

// File: rtl/fpe_timer.sv
module fpe_timer #(
  parameter int TMO_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [TMO_W-1:0] limit_i,
  input  logic             run_i,
  output logic             hit_o
);
  logic [TMO_W-1:0] elapsed_q;
  logic [TMO_W-1:0] limit_q;

  assign hit_o = run_i && (limit_q != '0) && (elapsed_q == limit_q - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elapsed_q <= '0;
      limit_q   <= '0;
    end else if (load_i) begin
      elapsed_q <= '0;
      limit_q   <= limit_i;
    end else if (run_i) begin
      elapsed_q <= elapsed_q + 1'b1;
    end
  end
endmodule

// File: rtl/fpe_gap.sv
module fpe_gap #(
  parameter int GAP_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [GAP_W-1:0] len_i,
  input  logic             run_i,
  output logic             expire_o
);
  logic [GAP_W-1:0] cnt_q;

  assign expire_o = run_i && (cnt_q <= GAP_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= len_i;
    end else if (run_i && cnt_q > GAP_W'(1)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/flash_poll_engine.sv
module flash_poll_engine
  import flash_poll_pkg::*;
#(
  parameter int         CLK_DIV   = 2,
  parameter int         IVL_W     = 8,
  parameter int         LEN_W     = 3,
  parameter int         TMO_W     = 24,
  parameter logic [7:0] STATUS_OP = 8'h05
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [7:0]       mask_i,
  input  logic [7:0]       match_i,
  input  logic [IVL_W-1:0] interval_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             auto_stop_i,
  input  logic [TMO_W-1:0] timeout_i,
  output logic             cmd_req_o,
  input  logic             cmd_ack_i,
  output logic [7:0]       cmd_opcode_o,
  output logic [LEN_W-1:0] cmd_len_o,
  input  logic             rx_valid_i,
  input  logic [7:0]       rx_byte_i,
  output logic             done_o,
  output logic             matched_o,
  output logic             timeout_o,
  output logic [7:0]       status_o
);
  localparam int GAP_W = IVL_W + $clog2(CLK_DIV + 1);

  poll_state_e      state_q, state_d;
  logic [7:0]       mask_q, match_q;
  logic [IVL_W-1:0] ivl_q;
  logic [LEN_W-1:0] len_q;
  logic             auto_q;
  logic             done_q, matched_q, timeout_q;
  logic [7:0]       status_q;

  // named internal events, observed by the checker
  logic busy, start_acc, req_fire, rx_fire;
  logic poll_end, poll_ok, tmo_hit, gap_expire;
  logic stop_match, finish;

  assign busy       = (state_q != ST_IDLE);
  assign start_acc  = start_i && !busy;
  assign req_fire   = (state_q == ST_REQ) && cmd_ack_i;
  assign rx_fire    = (state_q == ST_RECV) && rx_valid_i;
  assign stop_match = poll_end && poll_ok && auto_q;
  assign finish     = stop_match || tmo_hit;

  fpe_compare #(.LEN_W(LEN_W)) cmp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_i   (req_fire),
    .rx_fire_i (rx_fire),
    .rx_byte_i (rx_byte_i),
    .mask_i    (mask_q),
    .match_i   (match_q),
    .len_i     (len_q),
    .poll_end_o(poll_end),
    .poll_ok_o (poll_ok)
  );

  fpe_timer #(.TMO_W(TMO_W)) tmr_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (start_acc),
    .limit_i(timeout_i),
    .run_i  (busy),
    .hit_o  (tmo_hit)
  );

  fpe_gap #(.GAP_W(GAP_W)) gap_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (poll_end),
    .len_i   (GAP_W'(gap_len(32'(ivl_q), CLK_DIV))),
    .run_i   (state_q == ST_GAP),
    .expire_o(gap_expire)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_acc)  state_d = ST_REQ;
      ST_REQ:  if (cmd_ack_i)  state_d = ST_RECV;
      ST_RECV: if (poll_end)   state_d = ST_GAP;
      ST_GAP:  if (gap_expire) state_d = ST_REQ;
      default: state_d = ST_IDLE;
    endcase
    if (finish) state_d = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      mask_q    <= '0;
      match_q   <= '0;
      ivl_q     <= '0;
      len_q     <= LEN_W'(1);
      auto_q    <= 1'b0;
      done_q    <= 1'b0;
      matched_q <= 1'b0;
      timeout_q <= 1'b0;
      status_q  <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= finish;
      if (start_acc) begin
        mask_q    <= mask_i;
        match_q   <= match_i;
        ivl_q     <= interval_i;
        len_q     <= LEN_W'(eff_len(32'(len_i)));
        auto_q    <= auto_stop_i;
        matched_q <= 1'b0;
        timeout_q <= 1'b0;
      end else begin
        if (poll_end) matched_q <= poll_ok;
        if (finish)   timeout_q <= !stop_match;
      end
      if (rx_fire) status_q <= rx_byte_i;
    end
  end

  assign cmd_req_o    = (state_q == ST_REQ);
  assign cmd_opcode_o = STATUS_OP;
  assign cmd_len_o    = len_q;
  assign done_o       = done_q;
  assign matched_o    = matched_q;
  assign timeout_o    = timeout_q;
  assign status_o     = status_q;
endmodule

// File: rtl/fpe_checker.sv
module fpe_checker (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic cmd_req,
  input logic cmd_ack,
  input logic done,
  input logic matched,
  input logic timeout,
  input logic auto_q,
  input logic poll_end,
  input logic poll_ok,
  input logic tmo_hit
);
  // R10
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2
  a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req && !cmd_ack && !tmo_hit |=> cmd_req);

  // R2
  a_r2_req_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req |-> busy);

  // R4, R9
  a_r4_stop_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    poll_end && poll_ok && auto_q |=> done && matched && !timeout && !busy);

  // R7
  a_r7_timeout_end: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_hit && !(poll_end && poll_ok && auto_q) |=> done && timeout && !cmd_req);

  // R6
  a_r6_keep_polling: assert property (@(posedge clk) disable iff (!rst_n)
    poll_end && !auto_q && !tmo_hit |=> busy && !done);

  // R4
  a_r4_no_match_timeout: assert property (@(posedge clk) disable iff (!rst_n)
    auto_q && timeout |-> !matched);
endmodule

bind flash_poll_engine fpe_checker chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .busy    (busy),
  .cmd_req (cmd_req_o),
  .cmd_ack (cmd_ack_i),
  .done    (done_o),
  .matched (matched_o),
  .timeout (timeout_o),
  .auto_q  (auto_q),
  .poll_end(poll_end),
  .poll_ok (poll_ok),
  .tmo_hit (tmo_hit)
);

// File: tb/flash_poll_engine_tb_top.sv
module flash_poll_engine_tb_top;
  localparam int CLK_DIV = 2;
  localparam int IVL_W   = 4;
  localparam int LEN_W   = 3;
  localparam int TMO_W   = 12;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic [7:0]       mask_i = '0, match_i = '0;
  logic [IVL_W-1:0] interval_i = '0;
  logic [LEN_W-1:0] len_i = '0;
  logic             auto_stop_i = 1'b0;
  logic [TMO_W-1:0] timeout_i = '0;
  logic             cmd_req_o, cmd_ack_i = 1'b0;
  logic [7:0]       cmd_opcode_o;
  logic [LEN_W-1:0] cmd_len_o;
  logic             rx_valid_i = 1'b0;
  logic [7:0]       rx_byte_i = '0;
  logic             done_o, matched_o, timeout_o;
  logic [7:0]       status_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [7:0] bq [0:3];

  flash_poll_engine #(.CLK_DIV(CLK_DIV), .IVL_W(IVL_W), .LEN_W(LEN_W),
                      .TMO_W(TMO_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mask_i(mask_i),
    .match_i(match_i), .interval_i(interval_i), .len_i(len_i),
    .auto_stop_i(auto_stop_i), .timeout_i(timeout_i), .cmd_req_o(cmd_req_o),
    .cmd_ack_i(cmd_ack_i), .cmd_opcode_o(cmd_opcode_o), .cmd_len_o(cmd_len_o),
    .rx_valid_i(rx_valid_i), .rx_byte_i(rx_byte_i), .done_o(done_o),
    .matched_o(matched_o), .timeout_o(timeout_o), .status_o(status_o)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic go(input logic [7:0] m, input logic [7:0] v, input int ivl,
                    input int n, input bit as, input int tmo);
    mask_i = m; match_i = v; interval_i = IVL_W'(ivl); len_i = LEN_W'(n);
    auto_stop_i = as; timeout_i = TMO_W'(tmo);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // serve one poll of n bytes from bq; returns at the negedge after the last byte
  task automatic serve(input int n);
    while (!cmd_req_o) @(negedge clk);
    cmd_ack_i = 1'b1;
    @(negedge clk);
    cmd_ack_i = 1'b0;
    for (int i = 0; i < n; i++) begin
      rx_valid_i = 1'b1;
      rx_byte_i  = bq[i];
      @(negedge clk);
      rx_valid_i = 1'b0;
    end
  endtask

  task automatic count_gap(input int exp, input string tag);
    int cnt = 0;
    while (!cmd_req_o && cnt < 200) begin
      cnt++;
      @(negedge clk);
    end
    chk(cnt == exp, tag, cnt, exp);
  endtask

  task automatic wait_done(output int cnt);
    cnt = 1;
    while (!done_o && cnt < 1000) begin
      @(negedge clk);
      cnt++;
    end
  endtask

  initial begin
    int cnt;
    bit exp_m;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!cmd_req_o && !done_o && !matched_o && !timeout_o, "R1 flags", 
        {cmd_req_o, done_o, matched_o, timeout_o}, 0);
    chk(status_o == 8'h00, "R1 status", status_o, 0);

    // R3 sweep over all status values, R4 stop, R5 gap, R11 status
    for (int b = 0; b < 256; b++) begin
      exp_m = ((b & 8'h03) == 8'h02);
      go(8'h03, 8'h02, 3, 1, 1'b1, 0);
      bq[0] = 8'(b);
      serve(1);
      chk(status_o == 8'(b), "R11 last byte", status_o, b);
      if (exp_m) begin
        chk(done_o && matched_o && !timeout_o, "R3 R4 match stop", {done_o, matched_o, timeout_o}, 6);
      end else begin
        chk(!done_o, "R3 no match keeps polling", done_o, 0);
        count_gap(6, "R5 gap interval 3");
        bq[0] = 8'h06;
        serve(1);
        chk(done_o && matched_o, "R4 second poll match", {done_o, matched_o}, 3);
      end
      @(negedge clk);
      chk(!done_o, "R10 done one cycle", done_o, 0);
      repeat (8) @(negedge clk);
      chk(!cmd_req_o, "R4 no request after stop", cmd_req_o, 0);
    end

    // R5 gap with interval 0 and 15
    go(8'h01, 8'h00, 0, 1, 1'b1, 0);
    bq[0] = 8'h01; serve(1);
    count_gap(1, "R5 gap interval 0");
    bq[0] = 8'h00; serve(1);
    chk(done_o, "R5 end interval 0", done_o, 1);
    go(8'h01, 8'h00, 15, 1, 1'b1, 0);
    bq[0] = 8'h01; serve(1);
    count_gap(30, "R5 gap interval 15");
    bq[0] = 8'h00; serve(1);
    chk(done_o, "R5 end interval 15", done_o, 1);

    // R2 request fields, length 0 promoted to 1
    go(8'h02, 8'h02, 1, 0, 1'b1, 0);
    @(negedge clk);
    chk(cmd_req_o, "R2 request held", cmd_req_o, 1);
    chk(cmd_opcode_o == 8'h05, "R2 opcode", cmd_opcode_o, 8'h05);
    chk(cmd_len_o == 1, "R2 len zero as one", cmd_len_o, 1);
    bq[0] = 8'h02; serve(1);
    chk(done_o && matched_o, "R2 single byte poll", done_o, 1);

    // R3 multi-byte AND matching
    go(8'h01, 8'h00, 1, 3, 1'b1, 0);
    @(negedge clk);
    chk(cmd_len_o == 3, "R2 len three", cmd_len_o, 3);
    bq[0] = 8'h10; bq[1] = 8'h01; bq[2] = 8'h00; serve(3);
    chk(!done_o, "R3 one failing byte of three", done_o, 0);
    bq[0] = 8'h20; bq[1] = 8'h40; bq[2] = 8'h84; serve(3);
    chk(done_o && matched_o, "R3 all three pass", {done_o, matched_o}, 3);
    chk(status_o == 8'h84, "R11 last of three", status_o, 8'h84);

    // R6 no auto stop: keep polling past matches until timeout
    go(8'h02, 8'h02, 1, 1, 1'b0, 120);
    for (int p = 0; p < 3; p++) begin
      bq[0] = 8'h02; serve(1);
      chk(!done_o, "R6 match does not stop", done_o, 0);
    end
    wait_done(cnt);
    chk(done_o && timeout_o && matched_o, "R6 end matched", {done_o, timeout_o, matched_o}, 7);
    go(8'h02, 8'h02, 1, 1, 1'b0, 120);
    bq[0] = 8'h02; serve(1);
    bq[0] = 8'h00; serve(1);
    wait_done(cnt);
    chk(done_o && timeout_o && !matched_o, "R6 end last mismatch", {done_o, timeout_o, matched_o}, 6);

    // R7 timeout arrival
    foreach (bq[i]) bq[i] = 8'h00;
    for (int k = 0; k < 3; k++) begin
      int t;
      t = (k == 0) ? 5 : (k == 1) ? 1 : 37;
      go(8'h01, 8'h00, 1, 1, 1'b1, t);
      wait_done(cnt);
      chk(cnt == t + 1, "R7 timeout cycle", cnt, t + 1);
      chk(timeout_o && !matched_o && !cmd_req_o, "R7 timeout flags", {timeout_o, matched_o, cmd_req_o}, 4);
    end

    // R9 match in the expiring cycle
    go(8'h01, 8'h00, 1, 1, 1'b1, 2);
    bq[0] = 8'h00; serve(1);
    chk(done_o && matched_o && !timeout_o, "R9 match wins", {done_o, matched_o, timeout_o}, 6);
    go(8'h01, 8'h00, 1, 1, 1'b1, 2);
    bq[0] = 8'h01; serve(1);
    chk(done_o && !matched_o && timeout_o, "R9 mismatch times out", {done_o, matched_o, timeout_o}, 5);

    // R8 zero timeout never expires
    go(8'h01, 8'h00, 1, 1, 1'b1, 0);
    cnt = 0;
    for (int i = 0; i < 300; i++) begin
      if (done_o) cnt++;
      @(negedge clk);
    end
    chk(cnt == 0 && cmd_req_o, "R8 no timeout", cnt, 0);
    bq[0] = 8'h00; serve(1);
    chk(done_o && !timeout_o, "R8 ends on match", done_o, 1);

    // R10 start while busy ignored
    go(8'h01, 8'h00, 1, 1, 1'b1, 20);
    cnt = 1;
    while (!done_o && cnt < 400) begin
      if (cnt == 4) begin
        start_i = 1'b1; timeout_i = TMO_W'(100);
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
      cnt++;
    end
    start_i = 1'b0;
    chk(cnt == 21, "R10 restart ignored", cnt, 21);
    @(negedge clk);
    chk(!done_o, "R10 done pulse", done_o, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule